// File: doc/BRIEF.md
# Interrupt-to-Message Vector Controller

The block watches a bank of wired interrupt inputs and turns each one that is active, unmasked and message-enabled into a single interrupt message. Each message carries an 8-bit vector and an 8-bit destination selector. Both values are programmed per line by software. Each line is set by software as edge or level triggered and as active-high or active-low. Inputs are resynchronized into the block clock before any use. Edge events are latched until software clears them with a write-one-to-clear access.

Software reaches the block through a plain 32-bit register port. The port takes a word address, per-byte write enables, a write strobe and a combinational read data output. Messages leave on a valid/ready stream. When several lines are eligible, the lowest-numbered one goes first.

Back-pressure follows these rules. Once `msg_valid` is high, the vector and route stay unchanged until the cycle in which `msg_ready` is also high. That cycle is the transfer. A new message may be loaded in that same cycle, so the stream can carry one message per clock. A line that has produced a message stays quiet until its pending state falls and rises again.

Top module: `vecmsg_ctrl`

## Requirements
- R1: After reset every line is masked: the words at byte offsets 0x20 and 0x24 read 0xFFFFFFFF. The enable, trigger and polarity words read 0, all route and vector bytes read 0, and `msg_valid` is low.
- R2: Per-line bit registers hold line n in word n/32, bit n%32, with the second word 4 bytes above the first. The registers sit at these byte offsets: mask at 0x20 (1 masks), message enable at 0x40 (1 enables), trigger at 0x60 (1 = edge, 0 = level) and polarity at 0x3E0. Writes honour `cfg_be` per byte, and reads return the stored contents.
- R3: Line n has a vector byte at byte offset 0x200+n and a route byte at 0x100+n. A word access at 0x200+4k (or 0x100+4k) covers lines 4k..4k+3, with line 4k+b in byte b.
- R4: A level line is pending while its synchronized input XOR its polarity bit is 1, so polarity 1 means active-low. From an input change driven between edges, `msg_valid` rises after the third rising clock edge. No second message is sent while the line stays active. A new message follows once the line goes inactive and then active again.
- R5: An edge line with polarity 0 latches on a rising input and with polarity 1 on a falling input. The message appears after the fourth rising edge. The latch stays set after the input returns, and the line re-emits only after a clear and a new edge.
- R6: The clear register is at byte offset 0x80/0x84. Writing 1 to a bit drops that line's edge latch, and writing 0 changes nothing. Reading it returns the raw pending bits, whether the line is masked or not.
- R7: A message is produced only for a line whose mask bit is 0 and whose enable bit is 1. A line that is already pending emits as soon as it becomes unmasked or enabled.
- R8: When several lines are eligible, the lowest line number is sent first.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector` and `msg_route` stay constant. `msg_valid` falls only after a transfer.
- R10: Word offsets that are not listed above read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Asynchronous wired interrupt inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address (byte offset / 4) |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| msg_valid | output | 1 | Message on the output stream is valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Vector of the line being reported |
| msg_route | output | 8 | Destination selector of that line |

## Verification
Errors in the pending, latch or sent-flag state show up at the ports in one of three ways: a message that is missing, an extra message, or a message out of priority order. A scoreboard compares every transfer against the expected vector and route in order, so a wrong latch or sent flag is caught at the first transfer it disturbs. The raw pending bits read at the clear offset expose a wrong latch even while the line is masked. The latency checks pin the synchronizer and latch depth to exactly three or four edges. A single extra or missing register stage therefore shows within a few cycles of stimulus.

// File: rtl/vecmsg_pkg.sv
package vecmsg_pkg;
  // Byte offsets of the register groups
  localparam int OFF_MASK  = 'h020;
  localparam int OFF_MSGEN = 'h040;
  localparam int OFF_TRIG  = 'h060;
  localparam int OFF_CLR   = 'h080;
  localparam int OFF_ROUTE = 'h100;
  localparam int OFF_VEC   = 'h200;
  localparam int OFF_POL   = 'h3E0;

  localparam int WORD_BITS = 32;

  function automatic logic [31:0] be_merge(logic [31:0] old_w, logic [31:0] new_w,
                                           logic [3:0] be);
    logic [31:0] r;
    r = old_w;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/vecmsg_sync.sv
module vecmsg_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/vecmsg_pend.sv
module vecmsg_pend #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_sync,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] edge_lat,
  output logic [N-1:0] pending
);
  logic [N-1:0] act;
  logic [N-1:0] prev_q;

  assign act = raw_sync ^ pol;

  for (genvar n = 0; n < N; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[n]   <= 1'b0;
        edge_lat[n] <= 1'b0;
      end else begin
        prev_q[n] <= act[n];
        if (!trig[n])                   edge_lat[n] <= 1'b0;
        else if (act[n] && !prev_q[n])  edge_lat[n] <= 1'b1;
        else if (clr[n])                edge_lat[n] <= 1'b0;
      end
    end
    assign pending[n] = trig[n] ? edge_lat[n] : act[n];
  end
endmodule

// File: rtl/vecmsg_regs.sv
module vecmsg_regs
  import vecmsg_pkg::*;
#(
  parameter int N  = 64,
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  logic [N-1:0]      pending,
  output logic [31:0]       rdata,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      msgen,
  output logic [N-1:0]      trig,
  output logic [N-1:0]      pol,
  output logic [N-1:0]      clr_pulse,
  output logic [N-1:0][7:0] route,
  output logic [N-1:0][7:0] vec
);
  localparam int NW       = N / WORD_BITS;
  localparam int NQ       = N / 4;
  localparam int WA_MASK  = OFF_MASK / 4;
  localparam int WA_MSGEN = OFF_MSGEN / 4;
  localparam int WA_TRIG  = OFF_TRIG / 4;
  localparam int WA_CLR   = OFF_CLR / 4;
  localparam int WA_ROUTE = OFF_ROUTE / 4;
  localparam int WA_VEC   = OFF_VEC / 4;
  localparam int WA_POL   = OFF_POL / 4;

  int wa;
  assign wa = int'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '1;
      msgen <= '0;
      trig  <= '0;
      pol   <= '0;
      route <= '0;
      vec   <= '0;
    end else if (we) begin
      for (int w = 0; w < NW; w++) begin
        if (wa == WA_MASK + w)  mask[w*32 +: 32]  <= be_merge(mask[w*32 +: 32], wdata, be);
        if (wa == WA_MSGEN + w) msgen[w*32 +: 32] <= be_merge(msgen[w*32 +: 32], wdata, be);
        if (wa == WA_TRIG + w)  trig[w*32 +: 32]  <= be_merge(trig[w*32 +: 32], wdata, be);
        if (wa == WA_POL + w)   pol[w*32 +: 32]   <= be_merge(pol[w*32 +: 32], wdata, be);
      end
      for (int k = 0; k < NQ; k++) begin
        for (int b = 0; b < 4; b++) begin
          if (wa == WA_ROUTE + k && be[b]) route[4*k+b] <= wdata[8*b +: 8];
          if (wa == WA_VEC + k && be[b])   vec[4*k+b]   <= wdata[8*b +: 8];
        end
      end
    end
  end

  // One-cycle clear strobes from the write-one-to-clear word
  always_comb begin
    clr_pulse = '0;
    for (int w = 0; w < NW; w++) begin
      for (int b = 0; b < 4; b++) begin
        if (we && wa == WA_CLR + w && be[b]) clr_pulse[w*32 + 8*b +: 8] = wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (wa == WA_MASK + w)  rdata = mask[w*32 +: 32];
      if (wa == WA_MSGEN + w) rdata = msgen[w*32 +: 32];
      if (wa == WA_TRIG + w)  rdata = trig[w*32 +: 32];
      if (wa == WA_CLR + w)   rdata = pending[w*32 +: 32];
      if (wa == WA_POL + w)   rdata = pol[w*32 +: 32];
    end
    for (int k = 0; k < NQ; k++) begin
      for (int b = 0; b < 4; b++) begin
        if (wa == WA_ROUTE + k) rdata[8*b +: 8] = route[4*k+b];
        if (wa == WA_VEC + k)   rdata[8*b +: 8] = vec[4*k+b];
      end
    end
  end
endmodule

// File: rtl/vecmsg_arb.sv
module vecmsg_arb #(
  parameter int N = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pending,
  input  logic [N-1:0]      mask,
  input  logic [N-1:0]      msgen,
  input  logic [N-1:0][7:0] route,
  input  logic [N-1:0][7:0] vec,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [7:0]        msg_vector,
  output logic [7:0]        msg_route,
  output logic [N-1:0]      eligible,
  output logic [N-1:0]      launch
);
  localparam int LW = $clog2(N);

  logic [N-1:0]  sent_q;
  logic [LW-1:0] sel;
  logic          found;
  logic          slot_free;
  logic          do_launch;

  assign eligible = pending & ~mask & msgen & ~sent_q;

  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        sel   = LW'(i);
        found = 1'b1;
      end
    end
  end

  assign slot_free = !msg_valid || msg_ready;
  assign do_launch = slot_free && found;

  always_comb begin
    launch = '0;
    if (do_launch) launch[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_q     <= '0;
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_route  <= '0;
    end else begin
      sent_q <= (sent_q | launch) & pending;
      if (do_launch) begin
        msg_valid  <= 1'b1;
        msg_vector <= vec[sel];
        msg_route  <= route[sel];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vecmsg_ctrl.sv
module vecmsg_ctrl #(
  parameter int NUM_LINES   = 64,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_route
);
  logic [NUM_LINES-1:0]      raw_sync;
  logic [NUM_LINES-1:0]      mask, msgen, trig, pol, clr_pulse;
  logic [NUM_LINES-1:0]      edge_lat, pending, eligible, launch;
  logic [NUM_LINES-1:0][7:0] route_tab, vec_tab;

  vecmsg_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(raw_sync)
  );

  vecmsg_pend #(.N(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .raw_sync(raw_sync), .pol(pol), .trig(trig),
    .clr(clr_pulse), .edge_lat(edge_lat), .pending(pending)
  );

  vecmsg_regs #(.N(NUM_LINES), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .be(cfg_be),
    .wdata(cfg_wdata), .pending(pending), .rdata(cfg_rdata), .mask(mask),
    .msgen(msgen), .trig(trig), .pol(pol), .clr_pulse(clr_pulse),
    .route(route_tab), .vec(vec_tab)
  );

  vecmsg_arb #(.N(NUM_LINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .pending(pending), .mask(mask), .msgen(msgen),
    .route(route_tab), .vec(vec_tab), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_route(msg_route),
    .eligible(eligible), .launch(launch)
  );
endmodule

// File: rtl/vecmsg_ctrl_chk.sv
module vecmsg_ctrl_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [7:0]   msg_vector,
  input logic [7:0]   msg_route,
  input logic [N-1:0] eligible,
  input logic [N-1:0] launch,
  input logic [N-1:0] edge_lat,
  input logic [N-1:0] trig,
  input logic [N-1:0] clr_pulse,
  input logic [N-1:0] mask,
  input logic [N-1:0] msgen
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_route))); // R9
  AST_DROP_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_valid) |-> $past(msg_ready)); // R9
  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch)); // R8
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (launch != '0) |-> (((launch - ONE) & eligible) == '0)); // R8
  AST_GATED_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((launch & (mask | ~msgen)) == '0)); // R7
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_lat) & $past(trig) & ~$past(clr_pulse)) & ~edge_lat) == '0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && eligible == '0) |=> !msg_valid); // R7
endmodule

bind vecmsg_ctrl vecmsg_ctrl_chk #(.N(NUM_LINES)) u_chk (.*);

// File: tb/vecmsg_ctrl_test.sv
module vecmsg_ctrl_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [7:0]  msg_vector, msg_route;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] expq[$];
  string       tagq[$];
  logic [31:0] mask_lo = 32'hFFFF_FFFF, mask_hi = 32'hFFFF_FFFF;

  always #2 clk = ~clk;

  vecmsg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_route(msg_route)
  );

  function automatic logic [7:0] vec_of(int n);   return 8'(8'h40 + n);      endfunction
  function automatic logic [7:0] route_of(int n); return 8'(n) ^ 8'hA5;      endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int off, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    cfg_addr = 10'(off >> 2); cfg_wdata = d; cfg_be = be; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(int off, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = 10'(off >> 2);
    #1;
    chk(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  task automatic expect_msg(int n, string tag);
    expq.push_back({vec_of(n), route_of(n)});
    tagq.push_back(tag);
  endtask

  task automatic unmask(int n);
    if (n < 32) begin mask_lo[n] = 1'b0; wr('h20, mask_lo); end
    else begin mask_hi[n-32] = 1'b0; wr('h24, mask_hi); end
  endtask

  task automatic drain(string tag);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, tag, 32'(expq.size()), 0);
  endtask

  task automatic drive(int n, logic v);
    @(negedge clk);
    irq_in[n] = v;
  endtask

  // Scoreboard monitor: pops one expected item per transfer
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && !done) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL unexpected message actual=%h expected=none", {msg_vector, msg_route});
      end else begin
        logic [15:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({msg_vector, msg_route} !== e) begin
          failures++;
          $display("FAIL %s message actual=%h expected=%h", t, {msg_vector, msg_route}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd('h20, 32'hFFFF_FFFF, "R1 mask lo");
    rd('h24, 32'hFFFF_FFFF, "R1 mask hi");
    rd('h40, 0, "R1 enable");
    rd('h60, 0, "R1 trigger");
    rd('h3E4, 0, "R1 polarity");
    rd('h13C, 0, "R1 route");
    rd('h200, 0, "R1 vector");
    chk(msg_valid == 1'b0, "R1 no message", 32'(msg_valid), 0);

    // R10 undefined offsets
    wr('h10, 32'h1234_5678);
    rd('h10, 0, "R10 undefined read");
    rd('h300, 0, "R10 gap read");
    rd('h20, 32'hFFFF_FFFF, "R10 mask untouched");

    // R3 vector and route tables
    for (int k = 0; k < N / 4; k++) begin
      wr('h200 + 4*k, {vec_of(4*k+3), vec_of(4*k+2), vec_of(4*k+1), vec_of(4*k)});
      wr('h100 + 4*k, {route_of(4*k+3), route_of(4*k+2), route_of(4*k+1), route_of(4*k)});
    end
    rd('h228, {vec_of(43), vec_of(42), vec_of(41), vec_of(40)}, "R3 vector word");
    rd('h104, {route_of(7), route_of(6), route_of(5), route_of(4)}, "R3 route word");
    wr('h204, 32'h0000_7700, 4'b0010);
    rd('h204, {vec_of(7), vec_of(6), 8'h77, vec_of(4)}, "R3 byte write");
    wr('h204, {vec_of(7), vec_of(6), vec_of(5), vec_of(4)});

    // R2 bit registers with byte enables
    wr('h60, 32'h00FF_0000, 4'b0100);
    rd('h60, 32'h00FF_0000, "R2 trigger byte write");
    wr('h60, 0);
    wr('h40, ~(32'h1 << 12));
    wr('h44, 32'hFFFF_FFFF);
    rd('h40, ~(32'h1 << 12), "R2 enable readback");

    // R4 level line 3, active-high, latency three edges
    unmask(3);
    expect_msg(3, "R4 level");
    drive(3, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(msg_valid == 1'b1, "R4 level latency", 32'(msg_valid), 1);
    repeat (10) @(negedge clk);
    drive(3, 1'b0);
    repeat (5) @(negedge clk);
    expect_msg(3, "R4 level re-arm");
    drive(3, 1'b1);
    drain("R4 level messages");
    drive(3, 1'b0);

    // R4 active-low line 40, R6 pending readback while masked, R7 unmask
    wr('h3E4, 32'h1 << 8);
    repeat (5) @(negedge clk);
    rd('h84, 32'h1 << 8, "R6 raw pending masked");
    chk(msg_valid == 1'b0, "R7 masked quiet", 32'(msg_valid), 0);
    expect_msg(40, "R7 unmask releases");
    unmask(40);
    drain("R4 active-low message");
    drive(40, 1'b1);
    repeat (4) @(negedge clk);
    rd('h84, 0, "R4 active-low release");

    // R5 rising edge line 10, latency four edges
    wr('h60, 32'h1 << 10);
    unmask(10);
    expect_msg(10, "R5 rising edge");
    drive(10, 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(msg_valid == 1'b1, "R5 edge latency", 32'(msg_valid), 1);
    irq_in[10] = 1'b0;
    drain("R5 edge message");
    rd('h80, 32'h1 << 10, "R5 latch held");
    wr('h80, 0);
    rd('h80, 32'h1 << 10, "R6 zero write no effect");
    wr('h80, 32'h1 << 10);
    rd('h80, 0, "R6 clear drops latch");
    expect_msg(10, "R5 re-trigger");
    drive(10, 1'b1);
    drive(10, 1'b0);
    drain("R5 re-trigger message");
    wr('h80, 32'h1 << 10);

    // R5 falling edge line 33
    drive(33, 1'b1);
    repeat (4) @(negedge clk);
    wr('h3E4, (32'h1 << 8) | (32'h1 << 1));
    wr('h64, 32'h1 << 1);
    unmask(33);
    drain("R5 falling idle");
    expect_msg(33, "R5 falling edge");
    drive(33, 1'b0);
    drain("R5 falling message");

    // R8 priority and R9 back-pressure
    unmask(7);
    unmask(20);
    msg_ready = 1'b0;
    expect_msg(7, "R8 lowest first");
    expect_msg(20, "R8 next line");
    @(negedge clk);
    irq_in[7] = 1'b1;
    irq_in[20] = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk(msg_valid && msg_vector == vec_of(7) && msg_route == route_of(7),
          "R9 hold under back-pressure", {msg_valid, msg_vector, msg_route}, {1'b1, vec_of(7), route_of(7)});
    end
    msg_ready = 1'b1;
    drain("R8 both messages");
    irq_in[7] = 1'b0;
    irq_in[20] = 1'b0;

    // R7 enable gating on line 12
    unmask(12);
    drive(12, 1'b1);
    repeat (10) @(negedge clk);
    chk(msg_valid == 1'b0, "R7 disabled quiet", 32'(msg_valid), 0);
    rd('h80, 32'h1 << 12, "R7 pending while disabled");
    expect_msg(12, "R7 enable releases");
    wr('h40, 32'hFFFF_FFFF);
    drain("R7 enabled message");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule